// File: doc/BRIEF.md
# AES-128 Iterative Round Sequencer

This block is the control half of an iterative AES-128 engine that completes one round per clock. It waits for an encrypt or a decrypt request. It then steps the data path through a fixed linear walk of thirteen states: idle, an input-load state, ten round states and a hold state. The round transforms and the key expansion arithmetic sit elsewhere. This block only tells the data register and the round-key register when to load, and picks the key source. It also supplies the 8-bit round constant to the key expander, flags the last round so the column mix is skipped, and holds the mode bit that routes data through the forward or the inverse round path.

When the tenth round has been written, the sequencer parks in the hold state with both registers frozen, so the finished block stays on the data path output. It raises a one-cycle done pulse on entry to that state. It goes back to idle only once both request lines have been seen low, so a request line held high cannot start a second run by accident.

Top module: `aes_round_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the sequencer in idle. In the following cycle data_load_en, key_load_en, key_src_sel, final_round and done are 0 and rcon is 0x00.
- R2: In idle, both load enables stay 0 while enc_req and dec_req are low. A request seen high at a rising edge moves the sequencer to the load state for the next cycle.
- R3: In the load state, data_load_en and key_load_en are 1 and key_src_sel is 0, which selects the external key.
- R4: The load state is followed by exactly ten round-state cycles. In each of them data_load_en and key_load_en are 1 and key_src_sel is 1, which selects the generated key.
- R5: In an encrypt run, rcon is 0x01 in the load state. In round state k (k = 0..8) it is entry k+1 of the list 0x01,0x02,0x04,0x08,0x10,0x20,0x40,0x80,0x1B,0x36, counted from 0. In round state 9 it is 0x00.
- R6: In a decrypt run, the same constants are issued in reverse order: 0x36 in the load state, then 0x1B down to 0x01 in round states 0..8, then 0x00 in round state 9.
- R7: final_round is 1 in round state 9 and in no other cycle.
- R8: In the hold state, both load enables are 0 and rcon is 0x00. The sequencer stays in hold while either request line is high, and returns to idle at the first edge where both are low.
- R9: done is 1 only in the first cycle of the hold state.
- R10: mode_dec is captured when a run starts: 1 for dec_req alone, 0 when enc_req is high, so encrypt wins when both are high. It keeps that value until the next start. Requests that arrive between the load state and the hold state change neither the sequence nor mode_dec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enc_req | input | 1 | Encrypt request |
| dec_req | input | 1 | Decrypt request |
| data_load_en | output | 1 | Load enable for the data register |
| key_load_en | output | 1 | Load enable for the round-key register |
| key_src_sel | output | 1 | Key source: 0 external key, 1 generated key |
| rcon | output | 8 | Round constant to the key expander |
| final_round | output | 1 | Last round: bypass the column mix |
| mode_dec | output | 1 | Data path mode: 0 forward, 1 inverse |
| done | output | 1 | One-cycle pulse on entry to hold |

## Verification
The bench aims at the ends of the constant list. An off-by-one in the step index would issue 0x02 in the load state, or a non-zero constant in round 9. A decrypt run that failed to reverse the list would issue 0x01 first. It also holds a request line high through the hold state. A design that left hold on an edge instead of a level would start a second run at once. It raises the opposite request mid-run and both requests together at start, which catches a mode bit that is re-sampled while busy or that gives decrypt priority. A reset in the middle of a run checks that no load enable or constant survives it.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

  localparam int RCON_W = 8;
  localparam logic [RCON_W-1:0] GF_POLY = 8'h1B;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_ROUND = 2'd2,
    PH_HOLD  = 2'd3
  } seq_phase_t;

  // multiply by x in GF(2^8)
  function automatic logic [RCON_W-1:0] gf_xtime(input logic [RCON_W-1:0] v);
    logic [RCON_W-1:0] r;
    r = {v[RCON_W-2:0], 1'b0};
    if (v[RCON_W-1]) r = r ^ GF_POLY;
    return r;
  endfunction

  // constant number idx of the schedule: x^idx
  function automatic logic [RCON_W-1:0] rcon_at(input int idx);
    logic [RCON_W-1:0] v;
    v = 8'h01;
    for (int i = 0; i < idx; i++) v = gf_xtime(v);
    return v;
  endfunction

endpackage

// File: rtl/aes_seq_fsm.sv
module aes_seq_fsm
  import aes_seq_pkg::*;
#(
  parameter int NUM_ROUNDS = 10,
  localparam int RW = $clog2(NUM_ROUNDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enc_req,
  input  logic          dec_req,
  output seq_phase_t    phase,
  output logic [RW-1:0] rnd,
  output logic          mode_dec,
  output logic          done
);

  localparam logic [RW-1:0] LAST_RND = RW'(NUM_ROUNDS - 1);

  seq_phase_t    phase_d;
  logic [RW-1:0] rnd_d;
  logic          any_req;
  logic          start_evt;
  logic          last_step;

  assign any_req   = enc_req | dec_req;
  assign start_evt = (phase == PH_IDLE) && any_req;
  assign last_step = (phase == PH_ROUND) && (rnd == LAST_RND);

  always_comb begin
    phase_d = phase;
    rnd_d   = rnd;
    case (phase)
      PH_IDLE:  if (any_req) phase_d = PH_LOAD;
      PH_LOAD: begin
        phase_d = PH_ROUND;
        rnd_d   = '0;
      end
      PH_ROUND: begin
        if (rnd == LAST_RND) phase_d = PH_HOLD;
        else rnd_d = rnd + 1'b1;
      end
      PH_HOLD:  if (!any_req) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      rnd      <= '0;
      mode_dec <= 1'b0;
      done     <= 1'b0;
    end else begin
      phase <= phase_d;
      rnd   <= rnd_d;
      done  <= last_step;
      if (start_evt) mode_dec <= ~enc_req;
    end
  end

endmodule

// File: rtl/aes_seq_rcon.sv
module aes_seq_rcon
  import aes_seq_pkg::*;
#(
  parameter int NUM_ROUNDS = 10,
  localparam int RW = $clog2(NUM_ROUNDS)
) (
  input  logic              step_valid,
  input  logic [RW-1:0]     step,
  input  logic              mode_dec,
  output logic [RCON_W-1:0] rcon
);

  localparam logic [RW-1:0] LAST_IDX = RW'(NUM_ROUNDS - 1);

  logic [RCON_W-1:0] tbl [NUM_ROUNDS];
  logic [RW-1:0]     idx;

  for (genvar g = 0; g < NUM_ROUNDS; g++) begin : g_tbl
    assign tbl[g] = rcon_at(g);
  end

  // decrypt walks the schedule from its far end
  assign idx  = mode_dec ? (LAST_IDX - step) : step;
  assign rcon = step_valid ? tbl[idx] : '0;

endmodule

// File: rtl/aes_seq_decode.sv
module aes_seq_decode
  import aes_seq_pkg::*;
#(
  parameter int NUM_ROUNDS = 10,
  localparam int RW = $clog2(NUM_ROUNDS)
) (
  input  seq_phase_t    phase,
  input  logic [RW-1:0] rnd,
  output logic          data_load_en,
  output logic          key_load_en,
  output logic          key_src_sel,
  output logic          final_round,
  output logic          step_valid,
  output logic [RW-1:0] step
);

  localparam logic [RW-1:0] LAST_RND = RW'(NUM_ROUNDS - 1);

  always_comb begin
    data_load_en = 1'b0;
    key_load_en  = 1'b0;
    key_src_sel  = 1'b0;
    final_round  = 1'b0;
    step_valid   = 1'b0;
    step         = '0;
    case (phase)
      PH_LOAD: begin
        data_load_en = 1'b1;
        key_load_en  = 1'b1;
        step_valid   = 1'b1;
      end
      PH_ROUND: begin
        data_load_en = 1'b1;
        key_load_en  = 1'b1;
        key_src_sel  = 1'b1;
        if (rnd == LAST_RND) begin
          final_round = 1'b1;
        end else begin
          step_valid = 1'b1;
          step       = rnd + 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/aes_round_seq.sv
module aes_round_seq
  import aes_seq_pkg::*;
#(
  parameter int NUM_ROUNDS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enc_req,
  input  logic       dec_req,
  output logic       data_load_en,
  output logic       key_load_en,
  output logic       key_src_sel,
  output logic [7:0] rcon,
  output logic       final_round,
  output logic       mode_dec,
  output logic       done
);

  localparam int RW = $clog2(NUM_ROUNDS);

  seq_phase_t    phase;
  logic [RW-1:0] rnd;
  logic          step_valid;
  logic [RW-1:0] step;
  logic          in_idle;
  logic          in_hold;

  assign in_idle = (phase == PH_IDLE);
  assign in_hold = (phase == PH_HOLD);

  aes_seq_fsm #(.NUM_ROUNDS(NUM_ROUNDS)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .enc_req  (enc_req),
    .dec_req  (dec_req),
    .phase    (phase),
    .rnd      (rnd),
    .mode_dec (mode_dec),
    .done     (done)
  );

  aes_seq_decode #(.NUM_ROUNDS(NUM_ROUNDS)) u_dec (
    .phase        (phase),
    .rnd          (rnd),
    .data_load_en (data_load_en),
    .key_load_en  (key_load_en),
    .key_src_sel  (key_src_sel),
    .final_round  (final_round),
    .step_valid   (step_valid),
    .step         (step)
  );

  aes_seq_rcon #(.NUM_ROUNDS(NUM_ROUNDS)) u_rcon (
    .step_valid (step_valid),
    .step       (step),
    .mode_dec   (mode_dec),
    .rcon       (rcon)
  );

endmodule

// File: rtl/aes_round_seq_chk.sv
module aes_round_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       enc_req,
  input logic       dec_req,
  input logic       data_load_en,
  input logic       key_load_en,
  input logic       key_src_sel,
  input logic [7:0] rcon,
  input logic       final_round,
  input logic       mode_dec,
  input logic       done,
  input logic       in_idle,
  input logic       in_hold
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!data_load_en && !key_load_en && rcon == 8'h00 && !done && !final_round));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    in_idle |-> (!data_load_en && !key_load_en));

  p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
    (in_idle && (enc_req || dec_req)) |=> (data_load_en && key_load_en && !key_src_sel));

  p_final_in_round_r7: assert property (@(posedge clk) disable iff (rst)
    final_round |-> (data_load_en && key_load_en && key_src_sel && rcon == 8'h00));

  p_final_to_hold_r8: assert property (@(posedge clk) disable iff (rst)
    final_round |=> (in_hold && !data_load_en && !key_load_en));

  p_hold_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (in_hold && (enc_req || dec_req)) |=> in_hold);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_final_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (in_hold && $past(final_round)));

  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (data_load_en && $past(data_load_en)) |-> $stable(mode_dec));

endmodule

bind aes_round_seq aes_round_seq_chk u_chk (.*);

// File: tb/aes_round_seq_tb.sv
module aes_round_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_req = 1'b0;
  logic       dec_req = 1'b0;
  logic       data_load_en, key_load_en, key_src_sel, final_round, mode_dec, done;
  logic [7:0] rcon;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  aes_round_seq u_dut (
    .clk (clk), .rst (rst), .enc_req (enc_req), .dec_req (dec_req),
    .data_load_en (data_load_en), .key_load_en (key_load_en),
    .key_src_sel (key_src_sel), .rcon (rcon), .final_round (final_round),
    .mode_dec (mode_dec), .done (done)
  );

  // schedule written out, used forward or backward
  byte unsigned sched[$] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                             8'h20, 8'h40, 8'h80, 8'h1B, 8'h36};

  // model: pos -1 idle, 0 load, 1..10 rounds, 11 hold
  int m_pos = -1;
  bit m_dec = 1'b0;
  bit m_done = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos <= -1; m_dec <= 1'b0; m_done <= 1'b0;
    end else begin
      m_done <= (m_pos == 10);
      if (m_pos == -1) begin
        if (enc_req || dec_req) begin
          m_pos <= 0;
          m_dec <= !enc_req;
        end
      end else if (m_pos == 11) begin
        if (!enc_req && !dec_req) m_pos <= -1;
      end else begin
        m_pos <= m_pos + 1;
      end
    end
  end

  function automatic string tag_of(int p, bit d);
    if (p == -1) return "R2";
    if (p == 0) return d ? "R6/R3" : "R5/R3";
    if (p == 10) return "R7";
    if (p == 11) return "R8/R9";
    return d ? "R6/R4" : "R5/R4";
  endfunction

  task automatic compare(input string tag);
    logic [13:0] got, exp;
    byte unsigned e_rc;
    bit e_ld, e_ks;
    e_ld = (m_pos >= 0) && (m_pos <= 10);
    e_ks = (m_pos >= 1) && (m_pos <= 10);
    if (m_pos >= 0 && m_pos <= 9) e_rc = sched[m_dec ? 9 - m_pos : m_pos];
    else e_rc = 8'h00;
    exp = {e_ld, e_ld, e_ks, e_rc, (m_pos == 10), m_dec, m_done};
    got = {data_load_en, key_load_en, key_src_sel, rcon, final_round, mode_dec, done};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s pos=%0d actual=%h expected=%h", tag, m_pos, got, exp);
    end
  endtask

  task automatic step(input bit e, input bit d);
    @(negedge clk);
    compare((rst) ? "R1" : tag_of(m_pos, m_dec));
    enc_req = e;
    dec_req = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1 reset state");
    repeat (4) step(0, 0);                     // R2 idle stays quiet
    step(1, 0);                                // R5 encrypt start
    step(0, 0);
    for (int i = 0; i < 5; i++) step(0, 1);    // R10 ignored while busy
    for (int i = 0; i < 10; i++) step(0, 0);   // R8 leave hold
    step(0, 1);                                // R6 decrypt, held high
    for (int i = 0; i < 16; i++) step(0, 1);   // R8 sticky hold
    for (int i = 0; i < 3; i++) step(0, 0);
    step(1, 1);                                // R10 encrypt wins
    for (int i = 0; i < 14; i++) step(0, 0);
    step(0, 1);                                // R1 reset mid-run
    for (int i = 0; i < 4; i++) step(0, 0);
    rst = 1'b1;
    step(0, 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) step(0, 0);
    step(0, 1);                                // R6 decrypt after reset
    for (int i = 0; i < 14; i++) step(0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule